// File: doc/BRIEF.md
# Delegating Interrupt Priority Selector

This block decides, once per cycle, whether a hart has to take an interrupt and which one. It receives the raw pending and enable vectors, a per-source delegation mask, the current privilege level, and the machine and supervisor global interrupt-enable bits. It returns a take strobe and a complete cause word, ready to be written into a cause register by the trap-entry logic.

Every pending and enabled source is gated by one of two global conditions. Sources that are not delegated need the machine-level condition. Delegated sources need the supervisor-level condition. Each condition depends on the privilege level the hart runs at. Among the sources that survive this gating, the one with the smallest bit index wins. The result can be registered (one cycle of latency) or left combinational. The register width, 32 or 64, is a parameter.

Top module: `irq_prio_sel`

## Requirements
- R1: A source is a candidate only when both its pending bit and its enable bit are 1. A source that is pending but not enabled is never selected.
- R2: Privilege is encoded as U=0, S=1, M=3. The machine-level condition is true at U or S. At M it equals the machine global enable input.
- R3: The supervisor-level condition is true at U. At S it equals the supervisor global enable input. At M it is always false.
- R4: A candidate whose delegation bit is 0 is eligible only under the machine-level condition. A candidate whose delegation bit is 1 is eligible only under the supervisor-level condition.
- R5: When several sources are eligible, the source with the lowest bit index is selected.
- R6: When a source is selected, take is 1 and the cause word has bit XLEN-1 set. The selected index sits in bits $clog2(XLEN)-1:0, and every other bit is 0.
- R7: When no source is eligible, take is 0 and the cause word is all zeros.
- R8: With the registered option, the outputs reflect the inputs sampled at the previous rising clock edge. A synchronous active-low reset clears both outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset |
| pend_i | input | XLEN | Pending interrupt vector |
| en_i | input | XLEN | Per-source enable vector |
| deleg_i | input | XLEN | Delegation mask: 1 routes the source to the supervisor level |
| priv_i | input | 2 | Current privilege (U=0, S=1, M=3) |
| m_gie_i | input | 1 | Machine global interrupt enable |
| s_gie_i | input | 1 | Supervisor global interrupt enable |
| take_o | output | 1 | An interrupt must be taken |
| cause_o | output | XLEN | Cause word: interrupt flag in the MSB, index in the low bits |

## Verification
The bench builds the block with XLEN=64 and the registered output enabled. With this setting the highest source, index 63, can be selected, which proves that the interrupt flag in bit 63 and the index field in bits 5:0 do not overlap. It also exercises the one-cycle latency and the reset clearing the outputs while an eligible source is present. A sweep covers every legal privilege level against all four combinations of the two global enables, with random delegation, pending and enable masks. Each result is compared with an independent reference model.

// File: rtl/irq_sel_pkg.sv
// Shared types for the interrupt priority selector.
// Assumes the privilege encoding U=0, S=1, M=3; the value 2 is never driven.
package irq_sel_pkg;
    typedef enum logic [1:0] {
        PRIV_U = 2'd0,
        PRIV_S = 2'd1,
        PRIV_M = 2'd3
    } priv_t;
endpackage

// File: rtl/irq_gate.sv
// Per-source eligibility: forms candidates from pending and enable, then gates
// each candidate with the machine or supervisor global condition chosen by its
// delegation bit. Purely combinational. Assumes priv_i is never 2.
module irq_gate
    import irq_sel_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] pend_i,
    input  logic [XLEN-1:0] en_i,
    input  logic [XLEN-1:0] deleg_i,
    input  priv_t           priv_i,
    input  logic            m_gie_i,
    input  logic            s_gie_i,
    output logic [XLEN-1:0] cand_o,
    output logic [XLEN-1:0] elig_o,
    output logic            m_on_o,
    output logic            s_on_o
);
    // Global conditions per level, from privilege and enable bits
    always_comb begin
        m_on_o = (priv_i != PRIV_M) || m_gie_i;
        s_on_o = (priv_i == PRIV_U) || ((priv_i == PRIV_S) && s_gie_i);
    end

    assign cand_o = pend_i & en_i;

    // One gate per source, selected by its delegation bit
    for (genvar g = 0; g < XLEN; g++) begin : g_src
        assign elig_o[g] = cand_o[g] & (deleg_i[g] ? s_on_o : m_on_o);
    end
endmodule

// File: rtl/irq_pick.sv
// Lowest-index finder (trailing-zero count) over an eligibility vector.
// Combinational; idx_o is 0 when found_o is low.
module irq_pick #(
    parameter int XLEN = 64,
    localparam int IW  = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] vec_i,
    output logic            found_o,
    output logic [IW-1:0]   idx_o
);
    // Scan from the top so the lowest set bit is the last assignment
    always_comb begin
        idx_o = '0;
        for (int i = XLEN - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IW'(i);
        end
    end

    assign found_o = |vec_i;
endmodule

// File: rtl/irq_prio_sel.sv
// Top of the interrupt priority selector: gating, lowest-index pick, cause
// word formation and an optional output register (REG_OUT=1) with synchronous
// active-low reset. Assumes XLEN is 32 or 64 and priv_i is never 2.
module irq_prio_sel
    import irq_sel_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter bit REG_OUT = 1'b1,
    localparam int IW     = $clog2(XLEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] pend_i,
    input  logic [XLEN-1:0] en_i,
    input  logic [XLEN-1:0] deleg_i,
    input  logic [1:0]      priv_i,
    input  logic            m_gie_i,
    input  logic            s_gie_i,
    output logic            take_o,
    output logic [XLEN-1:0] cause_o
);
    if (XLEN != 32 && XLEN != 64) begin : g_bad_width
        $error("irq_prio_sel: XLEN must be 32 or 64");
    end

    logic [XLEN-1:0] cand, elig;
    logic            m_on, s_on, found;
    logic [IW-1:0]   idx;
    logic [XLEN-1:0] cause_d;

    irq_gate #(.XLEN(XLEN)) u_gate (
        .pend_i (pend_i),
        .en_i   (en_i),
        .deleg_i(deleg_i),
        .priv_i (priv_t'(priv_i)),
        .m_gie_i(m_gie_i),
        .s_gie_i(s_gie_i),
        .cand_o (cand),
        .elig_o (elig),
        .m_on_o (m_on),
        .s_on_o (s_on)
    );

    irq_pick #(.XLEN(XLEN)) u_pick (
        .vec_i  (elig),
        .found_o(found),
        .idx_o  (idx)
    );

    // Cause word: interrupt flag in the MSB, index in the low bits, else zero
    always_comb begin
        cause_d = '0;
        if (found) begin
            cause_d[XLEN-1] = 1'b1;
            cause_d[IW-1:0] = idx;
        end
    end

    if (REG_OUT) begin : g_reg
        // Output register, cleared by synchronous reset
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                take_o  <= 1'b0;
                cause_o <= '0;
            end else begin
                take_o  <= found;
                cause_o <= cause_d;
            end
        end

        logic [XLEN-1:0] sel_oh;
        assign sel_oh = XLEN'(1) << cause_o[IW-1:0];

        // R1
        cand_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
            take_o |-> (|($past(cand) & sel_oh)));
        // R2
        m_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (priv_i == 2'd3 && !m_gie_i) |-> !m_on);
        // R3
        s_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (priv_i == 2'd3) |-> !s_on);
        // R4
        gate_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
            take_o |-> ((|($past(deleg_i) & sel_oh)) ? $past(s_on) : $past(m_on)));
        // R5
        lowest_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
            take_o |-> (($past(elig) & (sel_oh - XLEN'(1))) == '0));
        // R6
        cause_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
            take_o |-> (cause_o[XLEN-1] && cause_o[XLEN-2:IW] == '0));
        // R7
        idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !take_o |-> (cause_o == '0));
        // R7
        none_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(elig) == '0) |-> !take_o);
    end else begin : g_comb
        assign take_o  = found;
        assign cause_o = cause_d;
    end
endmodule

// File: tb/irq_prio_sel_test.sv
module irq_prio_sel_test;
    localparam int XLEN   = 64;
    localparam int IW     = $clog2(XLEN);
    localparam time CLK_P = 10;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [XLEN-1:0] pend_i, en_i, deleg_i;
    logic [1:0]      priv_i;
    logic            m_gie_i, s_gie_i;
    logic            take_o;
    logic [XLEN-1:0] cause_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        logic            take;
        logic [XLEN-1:0] cause;
        string           tag;
    } exp_t;
    exp_t sb[$];

    irq_prio_sel #(.XLEN(XLEN), .REG_OUT(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .pend_i(pend_i), .en_i(en_i),
        .deleg_i(deleg_i), .priv_i(priv_i), .m_gie_i(m_gie_i),
        .s_gie_i(s_gie_i), .take_o(take_o), .cause_o(cause_o)
    );

    always #(CLK_P/2) clk = ~clk;

    // Reference model written from the requirements
    function automatic exp_t ref_model(logic [XLEN-1:0] p, logic [XLEN-1:0] e,
                                       logic [XLEN-1:0] d, logic [1:0] pv,
                                       logic mg, logic sg, string tag);
        exp_t r;
        logic mon, son;
        mon = (pv == 2'd0) || (pv == 2'd1) || (pv == 2'd3 && mg);
        son = (pv == 2'd0) || (pv == 2'd1 && sg);
        r.take = 1'b0; r.cause = '0; r.tag = tag;
        for (int i = 0; i < XLEN; i++) begin
            if (!r.take && p[i] && e[i] && (d[i] ? son : mon)) begin
                r.take = 1'b1;
                r.cause = (XLEN'(1) << (XLEN-1)) | XLEN'(i);
            end
        end
        return r;
    endfunction

    task automatic check(logic t, logic [XLEN-1:0] c, logic et,
                         logic [XLEN-1:0] ec, string tag);
        checks++;
        if (t !== et || c !== ec) begin
            fails++;
            $display("FAIL %s: take=%0b cause=%h expected take=%0b cause=%h",
                     tag, t, c, et, ec);
        end
    endtask

    // Driver: apply one stimulus at the falling edge and queue its expectation
    task automatic drive(logic [XLEN-1:0] p, logic [XLEN-1:0] e,
                         logic [XLEN-1:0] d, logic [1:0] pv,
                         logic mg, logic sg, string tag);
        @(negedge clk);
        pend_i = p; en_i = e; deleg_i = d; priv_i = pv;
        m_gie_i = mg; s_gie_i = sg;
        sb.push_back(ref_model(p, e, d, pv, mg, sg, tag));
    endtask

    // Monitor: a quarter period after each rising edge, compare with the queue head
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_P/4);
            if (sb.size() > 0) begin
                exp_t x;
                x = sb.pop_front();
                check(take_o, cause_o, x.take, x.cause, x.tag);
            end
        end
    end

    // Watchdog
    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [XLEN-1:0] all1;
        all1 = '1;
        rst_n = 1'b0;
        pend_i = all1; en_i = all1; deleg_i = '0; priv_i = 2'd0;
        m_gie_i = 1'b1; s_gie_i = 1'b1;
        repeat (2) @(posedge clk);
        #(CLK_P/4);
        // R8: reset holds outputs low although a source is eligible
        check(take_o, cause_o, 1'b0, '0, "R8");
        @(negedge clk);
        rst_n = 1'b1;

        // R1: pending but not enabled, and enabled but not pending
        drive(all1, '0, '0, 2'd0, 1, 1, "R1");
        drive('0, all1, '0, 2'd0, 1, 1, "R1");
        drive(64'h0000_00F0, 64'h0000_0F80, '0, 2'd3, 1, 0, "R1");
        // R2: machine-level gating
        drive(64'h10, all1, '0, 2'd3, 0, 1, "R2");
        drive(64'h10, all1, '0, 2'd3, 1, 0, "R2");
        drive(64'h10, all1, '0, 2'd1, 0, 0, "R2");
        drive(64'h10, all1, '0, 2'd0, 0, 0, "R2");
        // R3: supervisor-level gating
        drive(64'h20, all1, all1, 2'd1, 1, 0, "R3");
        drive(64'h20, all1, all1, 2'd1, 0, 1, "R3");
        drive(64'h20, all1, all1, 2'd3, 1, 1, "R3");
        drive(64'h20, all1, all1, 2'd0, 0, 0, "R3");
        // R4: mixed routing - delegated low source blocked at M, machine source wins
        drive(64'h0000_0101, all1, 64'h1, 2'd3, 1, 1, "R4");
        drive(64'h0000_0101, all1, 64'h100, 2'd1, 0, 1, "R4");
        // R5: several eligible, lowest index wins
        drive(64'h8000_0000_0000_0C08, all1, '0, 2'd0, 0, 0, "R5");
        drive(all1, all1, '0, 2'd3, 1, 0, "R5");
        // R6: extreme indices
        drive(64'h8000_0000_0000_0000, all1, '0, 2'd3, 1, 0, "R6");
        drive(64'h1, all1, '0, 2'd3, 1, 0, "R6");
        // R7: nothing eligible
        drive(all1, all1, all1, 2'd3, 1, 1, "R7");
        // R4: sweep privilege x enable pairs with random masks
        foreach (priv_list[k]) begin
            for (int g = 0; g < 4; g++) begin
                for (int n = 0; n < 20; n++) begin
                    drive({$urandom, $urandom}, {$urandom, $urandom},
                          {$urandom, $urandom}, priv_list[k], g[1], g[0], "R4");
                end
            end
        end
        // R8: synchronous reset in the middle clears the outputs
        drive(64'h4, all1, '0, 2'd0, 0, 0, "R8");
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #(CLK_P/4);
        check(take_o, cause_o, 1'b0, '0, "R8");
        @(negedge clk);
        rst_n = 1'b1;
        // R8: one cycle after release the sampled input appears
        drive(64'h4, all1, '0, 2'd0, 0, 0, "R8");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    logic [1:0] priv_list [3] = '{2'd0, 2'd1, 2'd3};
endmodule